// File: doc/BRIEF.md
# Atomic Multi-Word Probe Register Bank

This block places a set of input probes and output probes on a narrow internal register bus. Every register on that bus carries 16 bits, so a probe wider than that occupies a run of neighbouring addresses. Each probe has a shadow copy inside the bank. The rest of the chip therefore sees every probe change in one step and never in 16-bit pieces.

An output probe collects bus writes in its shadow buffer. It releases the whole buffer to its fabric pins only when the highest register of that probe is written. An input probe freezes the live fabric value into its snapshot when the lowest register of that probe is read. Reads of the higher registers return slices of that frozen value. A host can therefore stream a wide value over several bus cycles and still get a coherent result.

The probe widths are parameters, set per probe, with a minimum of one bit. All input probes come first in the address space and the output probes follow. The layout starts at a configurable base address.

Top module: `probe_bank`

## Requirements
- R1: Registers are 16 bits wide. A probe of width w takes ceil(w/16) consecutive addresses. Input probes are laid out first, in index order, starting at BASE. Output probes follow directly after the last input register. The lowest address of a probe holds its bits [15:0], the next address holds bits [31:16], and so on.
- R2: A write (bus_valid=1, bus_we=1) to any register of an output probe other than its highest one updates that slice of the probe's buffer. It leaves out_probe_bus unchanged.
- R3: A write to the highest register of an output probe updates that slice. The whole buffer, including the new slice, then appears on the probe's bits of out_probe_bus on the following clock.
- R4: A read of an output probe register returns the matching buffer slice. Bits above the probe width read as zero.
- R5: A read of the lowest register of an input probe captures the complete live input into the snapshot. The data returned is the low slice of that freshly captured value.
- R6: A read of any other register of an input probe returns the stored snapshot slice and does not recapture the live input.
- R7: Read data appears on bus_rdata one clock after the request and holds until the next read request.
- R8: An access to an address outside the bank returns zero on a read and changes no buffer, snapshot or output.
- R9: A synchronous active-high reset clears out_probe_bus, every buffer, every snapshot and bus_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| in_probe_bus | input | IN_TOTAL | All input probes packed, probe 0 at the LSBs |
| out_probe_bus | output | OUT_TOTAL | All output probes packed, probe 0 at the LSBs |

## Verification
The key same-cycle case is a first-register read of an input probe. In that cycle the snapshot capture and the read-data return both happen, so the returned word must be the slice of the value being captured, not the older snapshot. The bench provokes this by changing the live input on the very cycle of the read request. It then judges two things. The read data must match the new live value. A following upper-register read, issued after the live input has changed again, must still return the slice frozen at that earlier read.

// File: rtl/probe_bank_pkg.sv
package probe_bank_pkg;
    localparam int REG_W      = 16;
    localparam int MAX_PROBES = 8;

    typedef int width_list_t [MAX_PROBES];

    function automatic int regs_for(input int w);
        return (w + REG_W - 1) / REG_W;
    endfunction

    function automatic int sum_bits(input width_list_t w, input int n);
        int s = 0;
        for (int i = 0; i < n; i++) s += w[i];
        return s;
    endfunction

    function automatic int sum_regs(input width_list_t w, input int n);
        int s = 0;
        for (int i = 0; i < n; i++) s += regs_for(w[i]);
        return s;
    endfunction
endpackage

// File: rtl/probe_in_slot.sv
module probe_in_slot
    import probe_bank_pkg::*;
#(
    parameter int W    = 8,
    parameter int BASE = 0,
    parameter int AW   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_valid,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [W-1:0]     live,
    output logic             hit,
    output logic [REG_W-1:0] rdata
);
    localparam int NREG = regs_for(W);
    localparam int PADW = NREG * REG_W;

    typedef struct packed {
        logic [W-1:0] snap;
    } st_t;

    st_t st_d, st_q;
    int  idx;
    logic rd_first;
    logic [PADW-1:0] pad;

    assign idx      = int'(bus_addr) - BASE;
    assign hit      = bus_valid && !bus_we && (idx >= 0) && (idx < NREG);
    assign rd_first = hit && (idx == 0);

    always_comb begin
        st_d  = st_q;
        rdata = '0;
        if (rd_first) st_d.snap = live;
        pad = PADW'(st_d.snap);
        if (hit) rdata = pad[idx*REG_W +: REG_W];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    AST_SNAP_ONLY_FIRST: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(st_q.snap)) |-> $past(rd_first)); // R6
endmodule

// File: rtl/probe_out_slot.sv
module probe_out_slot
    import probe_bank_pkg::*;
#(
    parameter int W    = 8,
    parameter int BASE = 0,
    parameter int AW   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_valid,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic             hit,
    output logic [REG_W-1:0] rdata,
    output logic [W-1:0]     port
);
    localparam int NREG = regs_for(W);
    localparam int PADW = NREG * REG_W;

    typedef struct packed {
        logic [W-1:0] shadow;
        logic [W-1:0] port;
    } st_t;

    st_t st_d, st_q;
    int  idx;
    logic in_range, wr_hit, rd_hit, wr_last;
    logic [PADW-1:0] wpad, rpad;

    assign idx      = int'(bus_addr) - BASE;
    assign in_range = (idx >= 0) && (idx < NREG);
    assign wr_hit   = bus_valid && bus_we && in_range;
    assign rd_hit   = bus_valid && !bus_we && in_range;
    assign wr_last  = wr_hit && (idx == NREG - 1);
    assign hit      = rd_hit;
    assign port     = st_q.port;

    always_comb begin
        st_d  = st_q;
        rdata = '0;
        wpad  = PADW'(st_q.shadow);
        rpad  = PADW'(st_q.shadow);
        if (wr_hit) begin
            wpad[idx*REG_W +: REG_W] = bus_wdata;
            st_d.shadow = wpad[W-1:0];
            if (idx == NREG - 1) st_d.port = wpad[W-1:0];
        end
        if (rd_hit) rdata = rpad[idx*REG_W +: REG_W];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    AST_PORT_ONLY_LAST: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(st_q.port)) |-> $past(wr_last)); // R2
    AST_PORT_EQ_BUF: assert property (@(posedge clk) disable iff (rst)
        $past(wr_last) |-> (st_q.port == st_q.shadow)); // R3
endmodule

// File: rtl/probe_bank.sv
module probe_bank
    import probe_bank_pkg::*;
#(
    parameter int          AW      = 8,
    parameter int          BASE    = 16,
    parameter int          NUM_IN  = 3,
    parameter int          NUM_OUT = 2,
    parameter width_list_t IN_W    = '{5, 20, 1, 0, 0, 0, 0, 0},
    parameter width_list_t OUT_W   = '{2, 33, 0, 0, 0, 0, 0, 0},
    localparam int IN_TOTAL  = sum_bits(IN_W, NUM_IN),
    localparam int OUT_TOTAL = sum_bits(OUT_W, NUM_OUT)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_valid,
    input  logic                 bus_we,
    input  logic [AW-1:0]        bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    input  logic [IN_TOTAL-1:0]  in_probe_bus,
    output logic [OUT_TOTAL-1:0] out_probe_bus
);
    localparam int OUT_BASE = BASE + sum_regs(IN_W, NUM_IN);

    typedef struct packed {
        logic [REG_W-1:0] rdata;
    } st_t;

    st_t st_d, st_q;
    logic [REG_W-1:0] rd_in  [NUM_IN];
    logic [REG_W-1:0] rd_out [NUM_OUT];
    logic [NUM_IN-1:0]  hit_in;
    logic [NUM_OUT-1:0] hit_out;
    logic any_hit;
    logic [REG_W-1:0] rd_or;

    for (genvar g = 0; g < NUM_IN; g++) begin : g_in
        localparam int RB = BASE + sum_regs(IN_W, g);
        localparam int BO = sum_bits(IN_W, g);
        probe_in_slot #(.W(IN_W[g]), .BASE(RB), .AW(AW)) u_slot (
            .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
            .bus_addr(bus_addr), .live(in_probe_bus[BO +: IN_W[g]]),
            .hit(hit_in[g]), .rdata(rd_in[g]));
    end

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        localparam int RB = OUT_BASE + sum_regs(OUT_W, g);
        localparam int BO = sum_bits(OUT_W, g);
        probe_out_slot #(.W(OUT_W[g]), .BASE(RB), .AW(AW)) u_slot (
            .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
            .bus_addr(bus_addr), .bus_wdata(bus_wdata),
            .hit(hit_out[g]), .rdata(rd_out[g]),
            .port(out_probe_bus[BO +: OUT_W[g]]));
    end

    assign any_hit   = (|hit_in) || (|hit_out);
    assign bus_rdata = st_q.rdata;

    always_comb begin
        rd_or = '0;
        for (int i = 0; i < NUM_IN; i++)  rd_or |= rd_in[i];
        for (int i = 0; i < NUM_OUT; i++) rd_or |= rd_out[i];
        st_d = st_q;
        if (bus_valid && !bus_we) st_d.rdata = rd_or;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    AST_OOR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_we && !any_hit) |=> (bus_rdata == '0)); // R8
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bus_rdata == '0 && out_probe_bus == '0)); // R9
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(bus_rdata)) |-> $past(bus_valid && !bus_we)); // R7
endmodule

// File: tb/sim_probe_bank.sv
module sim_probe_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [25:0] in_probe_bus = '0;
    logic [34:0] out_probe_bus;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    probe_bank u0 (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .in_probe_bus(in_probe_bus), .out_probe_bus(out_probe_bus));

    // Map: in0 @16, in1 @17..18, in2 @19, out0 @20, out1 @21..23.
    typedef struct packed {
        logic        we;
        logic [7:0]  addr;
        logic [15:0] wd;
        logic [25:0] live;
        logic [15:0] exp_rd;
        logic [34:0] exp_out;
    } vec_t;

    localparam logic [25:0] LA = 26'h2ABCDEF;
    localparam logic [34:0] O1 = 35'h5_5556_AAA8;
    localparam logic [34:0] O2 = 35'h5_5556_AAAB;

    localparam vec_t VEC [14] = '{
        '{1'b1, 8'd21, 16'hAAAA, 26'h0, 16'h0,    35'h0}, // R2 low slice held
        '{1'b1, 8'd22, 16'h5555, 26'h0, 16'h0,    35'h0}, // R2 middle slice held
        '{1'b1, 8'd23, 16'hFFFF, 26'h0, 16'h0,    O1},    // R3 R1 commit on top reg
        '{1'b0, 8'd23, 16'h0,    26'h0, 16'h0001, O1},    // R4 unused bits zero
        '{1'b1, 8'd20, 16'hFFFF, 26'h0, 16'h0,    O2},    // R3 single-reg probe
        '{1'b0, 8'd20, 16'h0,    26'h0, 16'h0003, O2},    // R4 R1
        '{1'b0, 8'd18, 16'h0,    LA,    16'h0000, O2},    // R6 no capture yet
        '{1'b0, 8'd17, 16'h0,    LA,    16'h5E6F, O2},    // R5 fresh low slice
        '{1'b0, 8'd18, 16'h0,    26'h0, 16'h0005, O2},    // R6 R1 frozen upper
        '{1'b0, 8'd16, 16'h0,    26'h0, 16'h0000, O2},    // R5 in0 capture
        '{1'b0, 8'd19, 16'h0,    LA,    16'h0001, O2},    // R5 R1 in2 bit 25
        '{1'b0, 8'd30, 16'h0,    LA,    16'h0000, O2},    // R8 read outside
        '{1'b1, 8'd30, 16'hFFFF, LA,    16'h0,    O2},    // R8 write outside
        '{1'b0, 8'd17, 16'h0,    26'h0, 16'h0000, O2}     // R5 recapture
    };

    task automatic check(input string req, input string what,
                         input logic [34:0] act, input logic [34:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [7:0] a,
                          input logic [15:0] d, input logic [25:0] live);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        in_probe_bus = live;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9", "reset rdata", 35'(bus_rdata), 35'h0);
        check("R9", "reset outputs", out_probe_bus, 35'h0);
        rst = 1'b0;

        for (int i = 0; i < 14; i++) begin
            access(VEC[i].we, VEC[i].addr, VEC[i].wd, VEC[i].live);
            if (!VEC[i].we)
                check("R1-table", $sformatf("vec %0d rdata", i),
                      35'(bus_rdata), 35'(VEC[i].exp_rd));
            check("R1-table", $sformatf("vec %0d outputs", i),
                  out_probe_bus, VEC[i].exp_out);
        end

        // R7: read data held across idle cycles
        access(1'b0, 8'd22, 16'h0, 26'h0);
        check("R4", "buffer middle slice", 35'(bus_rdata), 35'h5555);
        repeat (2) @(negedge clk);
        check("R7", "rdata held", 35'(bus_rdata), 35'h5555);

        // R2: lower write after commit does not move outputs
        access(1'b1, 8'd21, 16'h1234, 26'h0);
        check("R2", "outputs after low write", out_probe_bus, O2);
        access(1'b0, 8'd21, 16'h0, 26'h0);
        check("R2", "buffer took slice", 35'(bus_rdata), 35'h1234);

        // R9: reset mid-run clears buffers and snapshots
        access(1'b0, 8'd17, 16'h0, LA);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        check("R9", "outputs cleared", out_probe_bus, 35'h0);
        check("R9", "rdata cleared", 35'(bus_rdata), 35'h0);
        access(1'b0, 8'd22, 16'h0, LA);
        check("R9", "buffer cleared", 35'(bus_rdata), 35'h0);
        access(1'b0, 8'd18, 16'h0, LA);
        check("R9", "snapshot cleared", 35'(bus_rdata), 35'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R7 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule